// File: doc/BRIEF.md
# Three-Interval Gate Sequence Generator

This block drives the power switches of a hybrid converter that charges a bank of flying capacitors in parallel from the input and then stacks them in series ahead of a synchronous boost half-bridge. A free-running counter divides time into fixed switching periods of `PERIOD_TICKS` clock ticks. Two thresholds split each period: a charge threshold Z and a boost on-time threshold D. Positions below Z are the capacitor charge slot. Positions from Z up to D are the series slot, in which the boost low side is still on. Positions from D to the end of the period are the transfer slot, in which the boost high side conducts.

Both thresholds are clamped and then captured only at the boundary between periods, so a command that changes mid-period never distorts the period in flight. Every hand-over between the parallel and series groups, and between the low and high boost switches, is separated by `DEAD_TICKS` ticks in which neither switch of the pair is driven. A one-cycle strobe marks position 0 of each period, so a control loop can sample its measurements there.

Top module: `sc_boost_gate_seq`

## Requirements
- R1: While enable is high, the output position advances by one per clock and wraps after PERIOD_TICKS positions. `period_start` is high for exactly one cycle, at position 0. The first clock edge that sees enable high produces position 0 at the outputs, and every output is registered.
- R2: `gate_par` is high exactly at positions p with p < Zc.
- R3: `gate_ser` is high exactly at positions p with Zc + DEAD_TICKS <= p < Dc.
- R4: `gate_lo` is high exactly at positions p with DEAD_TICKS <= p < Dc.
- R5: `gate_hi` is high exactly at positions p with p >= Dc + DEAD_TICKS.
- R6: Zc = min(z_ticks, DMAX_TICKS). Dc is d_cmd clamped into the range [Zc, DMAX_TICKS]. The low-side on-time per period is therefore max(Dc - DEAD_TICKS, 0) ticks.
- R7: z_ticks and d_cmd are captured only when the next position is 0 (at the last position of a period, or while disabled). A change made mid-period first takes effect in the following period.
- R8: `gate_par` and `gate_ser` are never high together, nor are `gate_lo` and `gate_hi`. A switch turns on only after its partner has been off for at least one cycle.
- R9: The cycle after enable is seen low, or after a synchronous reset (rst_n low), every gate and the strobe are low. The position restarts at 0 when enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the sequence; low forces all outputs off |
| z_ticks | input | CNT_W | Charge slot length in ticks |
| d_cmd | input | CNT_W | Boost on-time command in ticks |
| gate_par | output | 1 | Parallel-charge switch group |
| gate_ser | output | 1 | Series-connection switch group |
| gate_lo | output | 1 | Boost low-side switch |
| gate_hi | output | 1 | Boost high-side switch |
| period_start | output | 1 | One-cycle strobe at position 0 |

## Verification
A wrong counter value or a wrongly latched threshold shows up within one period as a gate edge at the wrong position, or as a strobe spaced other than PERIOD_TICKS apart. A clamp fault shows up as a wrong low-side on-time, counted between two strobes. A missing dead band shows up in the very cycle of the hand-over, as two partner gates overlapping or turning on back to back. The bench sweeps every D value against several Z values, including values outside the legal range. It changes commands mid-period, and it interrupts the sequence with enable and with reset.

// File: rtl/gsq_pkg.sv
// Shared definitions for the gate sequence generator.
// Assumes four gate outputs, indexed by the enum below.
package gsq_pkg;
    typedef enum int {
        GATE_PAR = 0,
        GATE_SER = 1,
        GATE_LO  = 2,
        GATE_HI  = 3
    } gate_idx_e;
    localparam int NUM_GATES = 4;
endpackage

// File: rtl/gsq_period_cnt.sv
// Period position counter: counts 0..PERIOD_TICKS-1 while run is high,
// and is held at 0 while run is low. Assumes PERIOD_TICKS >= 2.
module gsq_period_cnt #(
    parameter int PERIOD_TICKS = 1000,
    parameter int CNT_W        = $clog2(PERIOD_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    assign at_last = (cnt == LAST);

    // advance the position, wrapping at the period end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (at_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gsq_duty_latch.sv
// Threshold capture: clamps the charge and on-time commands into their
// legal range and holds them for a whole period. Assumes DMAX_TICKS
// fits in CNT_W bits.
module gsq_duty_latch #(
    parameter int CNT_W      = 10,
    parameter int DMAX_TICKS = 850
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] z_in,
    input  logic [CNT_W-1:0] d_in,
    output logic [CNT_W-1:0] z_q,
    output logic [CNT_W-1:0] d_q
);
    localparam logic [CNT_W-1:0] DMAX_V = CNT_W'(DMAX_TICKS);

    logic [CNT_W-1:0] z_c;
    logic [CNT_W-1:0] d_c;

    // clamp Z to the on-time ceiling, then D into [Z, ceiling]
    always_comb begin
        z_c = (z_in > DMAX_V) ? DMAX_V : z_in;
        if (d_in < z_c) begin
            d_c = z_c;
        end else if (d_in > DMAX_V) begin
            d_c = DMAX_V;
        end else begin
            d_c = d_in;
        end
    end

    // capture only at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= '0;
            d_q <= '0;
        end else if (load) begin
            z_q <= z_c;
            d_q <= d_c;
        end
    end
endmodule

// File: rtl/gsq_window.sv
// Half-open position window: on is high when lo <= pos < hi.
// An empty window (hi <= lo) is never on.
module gsq_window #(
    parameter int BW = 11
) (
    input  logic [BW-1:0] pos,
    input  logic [BW-1:0] lo,
    input  logic [BW-1:0] hi,
    output logic          on
);
    // compare the position against both bounds
    always_comb begin
        on = (pos >= lo) && (pos < hi);
    end
endmodule

// File: rtl/sc_boost_gate_seq.sv
// Three-interval gate sequencer for a switched-capacitor boost stage.
// Charge slot [0,Z), series slot [Z+DT,D), low side [DT,D), and high
// side [D+DT,P). All outputs are registered, one cycle behind the count.
// Assumes DMAX_TICKS + DEAD_TICKS < PERIOD_TICKS.
module sc_boost_gate_seq #(
    parameter int PERIOD_TICKS = 1000,
    parameter int DEAD_TICKS   = 4,
    parameter int DMAX_TICKS   = 850,
    parameter int CNT_W        = $clog2(PERIOD_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] z_ticks,
    input  logic [CNT_W-1:0] d_cmd,
    output logic             gate_par,
    output logic             gate_ser,
    output logic             gate_lo,
    output logic             gate_hi,
    output logic             period_start
);
    import gsq_pkg::*;

    localparam int            BW  = CNT_W + 1;
    localparam logic [BW-1:0] DTX = BW'(DEAD_TICKS);
    localparam logic [BW-1:0] PX  = BW'(PERIOD_TICKS);

    logic [CNT_W-1:0]     cnt;
    logic                 at_last;
    logic [CNT_W-1:0]     z_q;
    logic [CNT_W-1:0]     d_q;
    logic [BW-1:0]        pos_x;
    logic [BW-1:0]        z_x;
    logic [BW-1:0]        d_x;
    logic [BW-1:0]        lo_b [NUM_GATES];
    logic [BW-1:0]        hi_b [NUM_GATES];
    logic [NUM_GATES-1:0] win_on;
    logic [NUM_GATES-1:0] gates_q;
    logic                 strobe_q;

    gsq_period_cnt #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .CNT_W       (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .cnt    (cnt),
        .at_last(at_last)
    );

    gsq_duty_latch #(
        .CNT_W     (CNT_W),
        .DMAX_TICKS(DMAX_TICKS)
    ) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .load (!enable || at_last),
        .z_in (z_ticks),
        .d_in (d_cmd),
        .z_q  (z_q),
        .d_q  (d_q)
    );

    assign pos_x = {1'b0, cnt};
    assign z_x   = {1'b0, z_q};
    assign d_x   = {1'b0, d_q};

    // window bounds of each gate for the current period
    always_comb begin
        lo_b[GATE_PAR] = '0;
        hi_b[GATE_PAR] = z_x;
        lo_b[GATE_SER] = z_x + DTX;
        hi_b[GATE_SER] = d_x;
        lo_b[GATE_LO]  = DTX;
        hi_b[GATE_LO]  = d_x;
        lo_b[GATE_HI]  = d_x + DTX;
        hi_b[GATE_HI]  = PX;
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_win
        gsq_window #(.BW(BW)) u_win (
            .pos(pos_x),
            .lo (lo_b[g]),
            .hi (hi_b[g]),
            .on (win_on[g])
        );
    end

    // register gates and strobe; force all low while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            gates_q  <= enable ? win_on : '0;
            strobe_q <= enable && (cnt == '0);
        end
    end

    assign gate_par     = gates_q[GATE_PAR];
    assign gate_ser     = gates_q[GATE_SER];
    assign gate_lo      = gates_q[GATE_LO];
    assign gate_hi      = gates_q[GATE_HI];
    assign period_start = strobe_q;
endmodule

// File: rtl/gsq_checker.sv
// Port-level protocol checks for the gate sequencer, bound to the top.
module gsq_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic gate_par,
    input logic gate_ser,
    input logic gate_lo,
    input logic gate_hi,
    input logic period_start
);
    assert_par_ser_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_par && gate_ser));

    assert_lo_hi_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));

    assert_lo_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> !$past(gate_hi));

    assert_hi_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(gate_lo));

    assert_ser_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ser) |-> !$past(gate_par));

    assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    assert_strobe_no_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> !gate_hi);

    assert_ser_in_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_ser |-> gate_lo);

    assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(gate_par || gate_ser || gate_lo || gate_hi || period_start));
endmodule

bind sc_boost_gate_seq gsq_checker u_gsq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .gate_par    (gate_par),
    .gate_ser    (gate_ser),
    .gate_lo     (gate_lo),
    .gate_hi     (gate_hi),
    .period_start(period_start)
);

// File: tb/sc_boost_gate_seq_bench.sv
module sc_boost_gate_seq_bench;
    localparam int P    = 40;
    localparam int DT   = 2;
    localparam int DMAX = 34;
    localparam int CW   = $clog2(P);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] z_ticks = '0;
    logic [CW-1:0] d_cmd = '0;
    logic gate_par, gate_ser, gate_lo, gate_hi, period_start;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model state
    int m_cnt = 0, m_z = 0, m_d = 0;
    logic e_par = 0, e_ser = 0, e_lo = 0, e_hi = 0, e_ps = 0;
    int pend_on = 0, prev_on = -1, lo_acc = 0;
    bit e_en = 0, full_ok = 0;

    always #4 clk = ~clk;

    sc_boost_gate_seq #(
        .PERIOD_TICKS(P), .DEAD_TICKS(DT), .DMAX_TICKS(DMAX), .CNT_W(CW)
    ) u_sc_boost_gate_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .z_ticks(z_ticks),
        .d_cmd(d_cmd), .gate_par(gate_par), .gate_ser(gate_ser),
        .gate_lo(gate_lo), .gate_hi(gate_hi), .period_start(period_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    function automatic int clz(input int z);
        return (z > DMAX) ? DMAX : z;
    endfunction

    function automatic int cld(input int d, input int zc);
        if (d < zc) return zc;
        if (d > DMAX) return DMAX;
        return d;
    endfunction

    // one clock: model the coming edge from current inputs, then check outputs
    task automatic step();
        if (!rst_n) begin
            {e_par, e_ser, e_lo, e_hi, e_ps} = '0;
            m_cnt = 0; m_z = 0; m_d = 0;
            e_en = 0;
        end else begin
            e_en  = enable;
            e_par = enable && (m_cnt < m_z);
            e_ser = enable && (m_cnt >= m_z + DT) && (m_cnt < m_d);
            e_lo  = enable && (m_cnt >= DT) && (m_cnt < m_d);
            e_hi  = enable && (m_cnt >= m_d + DT);
            e_ps  = enable && (m_cnt == 0);
            if (e_ps) pend_on = (m_d > DT) ? m_d - DT : 0;
            if (!enable || m_cnt == P - 1) begin
                m_z = clz(int'(z_ticks));
                m_d = cld(int'(d_cmd), m_z);
            end
            m_cnt = !enable ? 0 : ((m_cnt == P - 1) ? 0 : m_cnt + 1);
        end
        @(posedge clk);
        @(negedge clk);
        cycles++;
        chk(e_en ? "R2" : "R9", int'(gate_par), int'(e_par));
        chk(e_en ? "R3" : "R9", int'(gate_ser), int'(e_ser));
        chk(e_en ? "R4" : "R9", int'(gate_lo), int'(e_lo));
        chk(e_en ? "R5" : "R9", int'(gate_hi), int'(e_hi));
        chk(e_en ? "R1" : "R9", int'(period_start), int'(e_ps));
        chk("R8", int'(gate_par && gate_ser), 0);
        chk("R8", int'(gate_lo && gate_hi), 0);
        // R6: low-side on-time of each whole enabled period
        if (!e_en) begin
            full_ok = 0;
            lo_acc  = 0;
        end else if (e_ps) begin
            if (full_ok && prev_on >= 0) chk("R6", lo_acc, prev_on);
            prev_on = pend_on;
            full_ok = 1;
            lo_acc  = int'(gate_lo);
        end else begin
            lo_acc += int'(gate_lo);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int zl[6] = '{0, 1, 5, 18, 34, 39};
        @(negedge clk);
        run(3);                       // reset state, R9
        rst_n = 1'b1;
        run(2);
        z_ticks = CW'(zl[0]);
        d_cmd   = '0;
        enable  = 1'b1;
        run(P / 2);                   // later commands land mid-period (R7)
        for (int zi = 0; zi < 6; zi++) begin
            z_ticks = CW'(zl[zi]);
            for (int d = 0; d < P; d++) begin
                d_cmd = CW'(d);
                run(P);
            end
        end
        d_cmd = CW'(20);
        run(7);
        enable = 1'b0;                // R9 enable drop mid-period
        run(5);
        enable = 1'b1;
        run(2 * P + 3);
        rst_n = 1'b0;                 // R9 reset while running
        run(2);
        rst_n = 1'b1;
        enable = 1'b0;
        run(1);
        enable = 1'b1;
        z_ticks = CW'(10);
        d_cmd   = CW'(3);             // below Z, clamped (R6)
        run(2 * P + 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule